// File: doc/BRIEF.md
# Even/Odd Interleaved Dual-Engine FIR Filter

This block computes a full-length finite impulse response filter with two sequential multiply-accumulate engines that share the work by output index. The even engine produces the outputs for even input indices and the odd engine produces the outputs for odd input indices. Each engine applies every coefficient to its own window of the shared sample history. Because each engine takes a new job only on every second input sample, it has two sample periods to finish the taps for one result. No decimation follows the filter: a merge stage interleaves the two result streams back into one full-rate output in strictly increasing sample order.

Input samples arrive with a valid strobe. Outputs leave on a separate valid strobe with a fixed latency. Coefficients sit in a small writable store, one tap per address, and are loaded while the filter is idle. A synchronous reset zeroes the sample history and the output path, so that samples before index zero count as zero. The first sample after reset is handled by the even engine.

Top module: `fir_eo_dual`

## Requirements
- R1: For input index n, the output equals the sum over taps k = 0..NTAPS-1 of coef[k] * x[n-k]. Coefficients and samples are signed two's complement, and x at a negative index is zero.
- R2: Exactly one output is produced for every accepted input sample, and outputs leave in strictly increasing input index with no index skipped.
- R3: The output for a sample accepted on rising edge A is presented with y_valid high right after rising edge A + NTAPS + 2, and y_valid is high in no other cycle.
- R4: A write with coef_we high stores coef_data as the coefficient of tap coef_addr. Tap 0 weights the newest sample, so an impulse of value 1 at input index 0 yields the coefficients in tap order, tap 0 first.
- R5: While rst is high and in the cycle after it, y_valid and y_data are zero. Samples accepted before a reset do not contribute to any output after it.
- R6: Idle cycles between input samples, of any length at or above the minimum spacing, change neither the output values nor the latency.
- R7: Input samples must be at least (NTAPS+2)/2 clock cycles apart (integer division), so that each engine is idle when its next job arrives.
- R8: The accumulator is full precision. y_data is its low OW bits, with no rounding or saturation, so a sum of 2^33 with OW = 32 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(NTAPS) | Tap index of the coefficient being written |
| coef_data | input | CW | Signed coefficient value |
| x_valid | input | 1 | Input sample strobe |
| x_data | input | DW | Signed input sample |
| y_valid | output | 1 | Output sample strobe |
| y_data | output | OW | Low OW bits of the filter result |

## Verification
An impulse after a coefficient load shows that taps are stored and weighted in the right order, and that the even and odd results merge without a swap. Dense random samples at the minimum spacing check the engines' use of the shared circular history under the heaviest load. Random idle gaps show that the result depends only on sample order and not on timing. Full-scale negative operands push the sum past the output width and expose any truncation or sign error. A reset taken after nonzero data, followed by an impulse, shows whether stale history leaks into the new run.

// File: rtl/fir_eo_pkg.sv
package fir_eo_pkg;

    // Engine control state
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    // Which engine a sample index belongs to
    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_e;

    // Minimum input spacing in cycles so that each engine is idle when
    // its next job (two samples later) arrives
    function automatic int f_min_gap(input int ntaps);
        return (ntaps + 2) / 2;
    endfunction

    // History depth: the window plus the samples written during one job,
    // rounded up to a power of two so that the pointer wraps for free
    function automatic int f_hist_depth(input int ntaps);
        return 2 ** $clog2(ntaps + 2);
    endfunction

endpackage

// File: rtl/fir_eo_hist.sv
module fir_eo_hist #(
    parameter int DW  = 16,
    parameter int HD  = 16,
    parameter int HAW = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    output logic [HAW-1:0]           wr_ptr,
    input  logic [1:0][HAW-1:0]      rd_addr,
    output logic [1:0][DW-1:0]       rd_data
);

    logic [DW-1:0] mem [HD];

    // Circular buffer indexed by absolute sample index modulo HD
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HD; i++) begin
                mem[i] <= '0;
            end
            wr_ptr <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= wr_ptr + 1'b1;
        end
    end

    // One combinational read port per engine
    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

endmodule

// File: rtl/fir_eo_coef.sv
module fir_eo_coef #(
    parameter int CW    = 16,
    parameter int NTAPS = 8,
    parameter int TAW   = 3
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [TAW-1:0]       waddr,
    input  logic [CW-1:0]        wdata,
    input  logic [1:0][TAW-1:0]  rd_addr,
    output logic [1:0][CW-1:0]   rd_data
);

    logic [CW-1:0] mem [NTAPS];

    // Writes to addresses beyond the last tap are dropped
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < NTAPS)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

endmodule

// File: rtl/fir_eo_mac.sv
module fir_eo_mac
    import fir_eo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 8,
    parameter int HAW   = 4,
    parameter int TAW   = 3,
    parameter int AW    = 35,
    parameter int OW    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HAW-1:0]    base,
    output logic [HAW-1:0]    hist_addr,
    output logic [TAW-1:0]    tap_addr,
    input  logic [DW-1:0]     hist_q,
    input  logic [CW-1:0]     coef_q,
    output logic              res_v,
    output logic [OW-1:0]     res_d
);

    localparam int PW = DW + CW;
    localparam logic [TAW-1:0] LAST_TAP = TAW'(NTAPS - 1);

    eng_state_e           state;
    logic [TAW-1:0]       tap;
    logic [HAW-1:0]       base_r;
    logic signed [AW-1:0] acc;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc_nx;
    logic                 busy;

    assign busy      = (state == ENG_RUN);
    assign tap_addr  = tap;
    // Tap k reads the sample k positions older than the job's newest one
    assign hist_addr = base_r - HAW'(tap);

    always_comb begin
        prod   = $signed(hist_q) * $signed(coef_q);
        acc_nx = acc + AW'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            tap    <= '0;
            base_r <= '0;
            acc    <= '0;
            res_v  <= 1'b0;
            res_d  <= '0;
        end else begin
            res_v <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state  <= ENG_RUN;
                        tap    <= '0;
                        acc    <= '0;
                        base_r <= base;
                    end
                end
                ENG_RUN: begin
                    acc <= acc_nx;
                    if (tap == LAST_TAP) begin
                        state <= ENG_IDLE;
                        res_v <= 1'b1;
                        res_d <= acc_nx[OW-1:0];
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R7: a new job never reaches an engine that is still accumulating
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R2: each job ends in a single-cycle result strobe
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_v |=> !res_v);

    // R3: a result is flagged only as the engine leaves its run state
    done_leaves_run_chk: assert property (@(posedge clk) disable iff (rst)
        res_v |-> !busy);

endmodule

// File: rtl/fir_eo_merge.sv
module fir_eo_merge
    import fir_eo_pkg::*;
#(
    parameter int OW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          res_v,
    input  logic [1:0][OW-1:0]  res_d,
    output logic                y_valid,
    output logic [OW-1:0]       y_data
);

    logic [1:0]          hold_v;
    logic [1:0][OW-1:0]  hold_d;
    parity_e             next_par;
    logic                sel;

    assign sel = logic'(next_par);

    // Emit only the engine whose parity is next in sample order
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= '0;
            hold_d   <= '0;
            next_par <= PAR_EVEN;
            y_valid  <= 1'b0;
            y_data   <= '0;
        end else begin
            y_valid <= 1'b0;
            if (hold_v[sel]) begin
                y_valid      <= 1'b1;
                y_data       <= hold_d[sel];
                hold_v[sel]  <= 1'b0;
                next_par     <= (next_par == PAR_EVEN) ? PAR_ODD : PAR_EVEN;
            end
            for (int e = 0; e < 2; e++) begin
                if (res_v[e]) begin
                    hold_v[e] <= 1'b1;
                    hold_d[e] <= res_d[e];
                end
            end
        end
    end

    for (genvar e = 0; e < 2; e++) begin : g_chk
        // R2: a fresh result never lands on an unsent one
        hold_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
            res_v[e] |-> !hold_v[e]);
    end

    // R3: outputs are single-cycle strobes
    out_gap_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

endmodule

// File: rtl/fir_eo_dual.sv
module fir_eo_dual
    import fir_eo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 8,
    parameter int OW    = 32,
    localparam int TAW  = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             coef_we,
    input  logic [TAW-1:0]   coef_addr,
    input  logic [CW-1:0]    coef_data,
    input  logic             x_valid,
    input  logic [DW-1:0]    x_data,
    output logic             y_valid,
    output logic [OW-1:0]    y_data
);

    localparam int HD  = f_hist_depth(NTAPS);
    localparam int HAW = $clog2(HD);
    localparam int AW  = DW + CW + $clog2(NTAPS);

    logic [HAW-1:0]          wr_ptr;
    logic [1:0][HAW-1:0]     h_addr;
    logic [1:0][DW-1:0]      h_data;
    logic [1:0][TAW-1:0]     c_addr;
    logic [1:0][CW-1:0]      c_data;
    logic [1:0]              start;
    logic [1:0]              res_v;
    logic [1:0][OW-1:0]      res_d;
    parity_e                 in_par;

    // Input index parity: index 0 after reset goes to the even engine
    always_ff @(posedge clk) begin
        if (rst) begin
            in_par <= PAR_EVEN;
        end else if (x_valid) begin
            in_par <= (in_par == PAR_EVEN) ? PAR_ODD : PAR_EVEN;
        end
    end

    fir_eo_hist #(
        .DW  (DW),
        .HD  (HD),
        .HAW (HAW)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (x_valid),
        .wr_data (x_data),
        .wr_ptr  (wr_ptr),
        .rd_addr (h_addr),
        .rd_data (h_data)
    );

    fir_eo_coef #(
        .CW    (CW),
        .NTAPS (NTAPS),
        .TAW   (TAW)
    ) u_coef (
        .clk     (clk),
        .we      (coef_we),
        .waddr   (coef_addr),
        .wdata   (coef_data),
        .rd_addr (c_addr),
        .rd_data (c_data)
    );

    for (genvar e = 0; e < 2; e++) begin : g_eng
        assign start[e] = x_valid && (logic'(in_par) == 1'(e));

        fir_eo_mac #(
            .DW    (DW),
            .CW    (CW),
            .NTAPS (NTAPS),
            .HAW   (HAW),
            .TAW   (TAW),
            .AW    (AW),
            .OW    (OW)
        ) u_mac (
            .clk       (clk),
            .rst       (rst),
            .start     (start[e]),
            .base      (wr_ptr),
            .hist_addr (h_addr[e]),
            .tap_addr  (c_addr[e]),
            .hist_q    (h_data[e]),
            .coef_q    (c_data[e]),
            .res_v     (res_v[e]),
            .res_d     (res_d[e])
        );
    end

    fir_eo_merge #(
        .OW (OW)
    ) u_merge (
        .clk     (clk),
        .rst     (rst),
        .res_v   (res_v),
        .res_d   (res_d),
        .y_valid (y_valid),
        .y_data  (y_data)
    );

    // Outstanding-sample count, used only by the checks below
    logic [7:0] pend;
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= pend + {7'd0, x_valid} - {7'd0, y_valid};
        end
    end

    // R2: never more outputs than accepted inputs
    no_extra_out_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (pend != 8'd0));

    // R5: the output strobe is quiet in the cycle after reset
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !y_valid);

endmodule

// File: tb/fir_eo_dual_test.sv
module fir_eo_dual_test;

    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int NTAPS = 8;
    localparam int OW    = 32;
    localparam int TAW   = $clog2(NTAPS);
    localparam int GAP   = fir_eo_pkg::f_min_gap(NTAPS);
    localparam int LAT   = NTAPS + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            coef_we = 1'b0;
    logic [TAW-1:0]  coef_addr = '0;
    logic [CW-1:0]   coef_data = '0;
    logic            x_valid = 1'b0;
    logic [DW-1:0]   x_data = '0;
    logic            y_valid;
    logic [OW-1:0]   y_data;

    fir_eo_dual #(
        .DW    (DW),
        .CW    (CW),
        .NTAPS (NTAPS),
        .OW    (OW)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .x_valid   (x_valid),
        .x_data    (x_data),
        .y_valid   (y_valid),
        .y_data    (y_data)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    int          coef_m [NTAPS];
    int          hist_m [$];
    logic [OW-1:0] exp_d [$];
    int          exp_t [$];

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Output monitor: compares on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_t.size() > 0 && exp_t[0] == cyc) begin
                chk(y_valid == 1'b1, "R3", 64'(y_valid), 64'd1);
                if (y_valid) chk(y_data == exp_d[0], cur_req, 64'(y_data), 64'(exp_d[0]));
                void'(exp_t.pop_front());
                void'(exp_d.pop_front());
            end else if (y_valid) begin
                chk(1'b0, "R2", 64'(y_data), 64'd0);
            end
        end
    end

    task automatic write_coef(input int k, input int v);
        logic [CW-1:0] w;
        w = CW'(v);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = TAW'(k);
        coef_data = w;
        coef_m[k] = int'($signed(w));
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic send(input int v, input int gap);
        logic [DW-1:0] s;
        longint acc;
        logic [63:0] accb;
        s = DW'(v);
        @(negedge clk);
        x_valid = 1'b1;
        x_data  = s;
        hist_m.push_front(int'($signed(s)));
        if (hist_m.size() > NTAPS) void'(hist_m.pop_back());
        acc = 0;
        for (int k = 0; k < NTAPS; k++) begin
            if (k < hist_m.size()) acc += longint'(coef_m[k]) * longint'(hist_m[k]);
        end
        accb = 64'(acc);
        exp_d.push_back(accb[OW-1:0]);
        exp_t.push_back(cyc + 1 + LAT);
        @(negedge clk);
        x_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
        // R2: every accepted sample has produced its output
        chk(exp_t.size() == 0, "R2", 64'(exp_t.size()), 64'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R5: outputs are cleared while reset is held
        chk(y_valid == 1'b0, "R5", 64'(y_valid), 64'd0);
        chk(y_data == '0, "R5", 64'(y_data), 64'd0);
        hist_m.delete();
        rst = 1'b0;
        @(negedge clk);
        chk(y_valid == 1'b0, "R5", 64'(y_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(y_valid == 1'b0, "R5", 64'(y_valid), 64'd0);
        chk(y_data == '0, "R5", 64'(y_data), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4: impulse reads the coefficients back in tap order
        cur_req = "R4";
        for (int k = 0; k < NTAPS; k++) write_coef(k, (k + 1) * 3 - 5);
        send(1, GAP);
        for (int i = 0; i < NTAPS + 2; i++) send(0, GAP);
        drain();

        // R1 and R7: dense random data at the minimum spacing
        cur_req = "R1";
        for (int k = 0; k < NTAPS; k++) write_coef(k, int'($urandom_range(0, 65535)));
        for (int i = 0; i < 40; i++) send(int'($urandom_range(0, 65535)), GAP);
        drain();

        // R6: random idle gaps between samples
        cur_req = "R6";
        for (int i = 0; i < 40; i++)
            send(int'($urandom_range(0, 65535)), GAP + int'($urandom_range(0, 7)));
        drain();

        // R8: full-scale operands wrap in the low output bits
        cur_req = "R8";
        for (int k = 0; k < NTAPS; k++) write_coef(k, -32768);
        for (int i = 0; i < NTAPS + 2; i++) send(-32768, GAP);
        send(32767, GAP);
        send(-1, GAP);
        drain();

        // R5: stale history must not leak across a reset
        cur_req = "R5";
        for (int k = 0; k < NTAPS; k++) write_coef(k, k + 1);
        for (int i = 0; i < 5; i++) send(1000, GAP);
        drain();
        do_reset();
        send(1, GAP);
        for (int i = 0; i < NTAPS; i++) send(0, GAP + 1);
        drain();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule